// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segment number and a 32-bit offset into a linear address. It keeps six segment registers. Each one holds a visible 16-bit selector and a hidden cache of base, effective limit, rights byte and flag nibble. Translation reads only the hidden cache, in both modes. In real mode it adds the cached base to the offset. After a real-mode load, that base is the selector times sixteen. The offset is checked against the cached limit, and a failed check returns a fault code in place of an address.

A segment load uses a start/busy/done handshake. In real mode the load fills the cache at once from the selector. In protected mode the selector's upper thirteen bits index an 8-byte descriptor in a global table. The table's base and byte limit come in as inputs, and the descriptor is fetched with one 64-bit read on a request/acknowledge port. The fetched descriptor is decoded from its split fields and checked against the target register. It is committed to the cache only if no fault is found. While a fetch is outstanding, new translations and new loads are held off.

Segment numbers: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS; 6 and 7 are invalid. Fault codes: 0 none, 1 general protection, 2 stack fault, 3 not present.

Top module: `seg_xlate_unit`

## Requirements
- R1: With `prot_mode` low, a load to segment 0..5 sets that segment's selector to `ld_sel`, base to `ld_sel`*16, limit to 0xFFFF, rights to 0x93 and flags to 0. `ld_done` rises one cycle after the start with fault 0, and no memory read is made.
- R2: An accepted translation (`xl_valid` high while `xl_ready` high) produces `xl_out_valid` one cycle later with `xl_linear` = cached base + offset, modulo 2^32, and fault 0.
- R3: If the offset exceeds the cached limit, the translation returns fault 2 for segment 2 and fault 1 otherwise, with `xl_linear` 0. A translation or load naming segment 6 or 7 returns fault 1.
- R4: In protected mode, a load whose entry fits in the table raises `mem_req` with `mem_addr` = `gdt_base` + (`ld_sel`[15:3])*8. The request is held steady until `mem_ack`, exactly one read is made per load, and `ld_done` pulses in the cycle after the acknowledge.
- R5: Descriptor decode uses these bit positions: limit[15:0] at 15:0, base[15:0] at 31:16, base[23:16] at 39:32, rights at 47:40, limit[19:16] at 51:48, flags at 55:52, base[31:24] at 63:56. When flag bit 55 (granularity) is set, the cached limit is the 20-bit limit times 4096 plus 4095.
- R6: If entry byte index*8+7 exceeds `gdt_limit`, the load ends with fault 1 one cycle after the start. No read is made, and the selector and cache stay unchanged.
- R7: A descriptor with rights bit 4 (code/data) clear is rejected with fault 1. Segment 1 also rejects rights bit 3 (executable) clear, and segment 2 rejects bit 3 set. A rejected load leaves the selector and cache unchanged.
- R8: A descriptor that passes R7 but has rights bit 7 (present) clear ends with fault 3 and leaves the selector and cache unchanged.
- R9: A descriptor load without a fault stores the rights byte with bit 0 (accessed) forced to 1, and stores the flag nibble unchanged.
- R10: Changing `prot_mode` never alters any selector or cache, and a segment not reloaded keeps its base, limit and rights.
- R11: While `ld_busy` is high, `xl_ready` is low, `xl_valid` produces no result, and `ld_start` is ignored.
- R12: After reset every segment has selector 0, base 0, limit 0xFFFF, rights 0x93 and flags 0, and `ld_busy`, `ld_done`, `mem_req` and `xl_out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_mode | input | 1 | 1 selects protected-mode loads |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table byte limit |
| ld_start | input | 1 | Start a segment load |
| ld_seg | input | 3 | Segment to load |
| ld_sel | input | 16 | Selector value to load |
| ld_busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | One-cycle load completion pulse |
| ld_fault | output | 2 | Load fault code, valid with ld_done |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Descriptor data |
| xl_valid | input | 1 | Translation request |
| xl_ready | output | 1 | Translation can be accepted |
| xl_seg | input | 3 | Segment for translation |
| xl_offset | input | 32 | Offset to translate |
| xl_out_valid | output | 1 | Translation result valid |
| xl_linear | output | 32 | Linear address |
| xl_fault | output | 2 | Translation fault code |
| obs_seg | input | 3 | Segment to observe |
| obs_sel | output | 16 | Observed visible selector |
| obs_rights | output | 8 | Observed cached rights byte |
| obs_flags | output | 4 | Observed cached flag nibble |

## Verification
A corrupted cache entry goes unseen until that segment is translated. It then shows as a wrong linear address, or as a limit fault at the wrong offset, in the cycle after the request. For that reason every load is followed at once by translations at offset zero, at the limit and one past the limit. The selector, rights and flags are read back through the observation port. A faulting load that wrongly commits is caught by the same readback, because the entry is compared against the bench model that still holds the old value. A fetch at the wrong address shows as the wrong descriptor decoded and as a mismatch in the captured request address.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W = 32;
  localparam int SEL_W  = 16;
  localparam int NSEG   = 6;
  localparam int SEG_W  = 3;
  localparam logic [SEG_W-1:0] SEG_CODE  = 3'd1;
  localparam logic [SEG_W-1:0] SEG_STACK = 3'd2;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_SF   = 2'd2,
    FLT_NP   = 2'd3
  } flt_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] lim;
    logic [7:0]        acc;
    logic [3:0]        flg;
  } seg_cache_t;

  localparam seg_cache_t CACHE_RESET = '{
    base: '0, lim: ADDR_W'(32'h0000_FFFF), acc: 8'h93, flg: 4'h0};
endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_xlate_pkg::*;
(
  input  logic [63:0]      desc,
  input  logic [SEG_W-1:0] seg,
  output seg_cache_t       entry,
  output flt_e             fault
);
  logic [19:0] raw_lim;
  logic        gran, present, code_data, exec;

  assign raw_lim   = {desc[51:48], desc[15:0]};
  assign gran      = desc[55];
  assign present   = desc[47];
  assign code_data = desc[44];
  assign exec      = desc[43];

  always_comb begin
    entry.base = {desc[63:56], desc[39:32], desc[31:16]};
    entry.lim  = gran ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
    entry.acc  = desc[47:40] | 8'h01;
    entry.flg  = desc[55:52];
  end

  always_comb begin
    if (!code_data)                      fault = FLT_GP;
    else if (seg == SEG_CODE && !exec)   fault = FLT_GP;
    else if (seg == SEG_STACK && exec)   fault = FLT_GP;
    else if (!present)                   fault = FLT_NP;
    else                                 fault = FLT_NONE;
  end
endmodule

// File: rtl/seg_cache_file.sv
module seg_cache_file
  import seg_xlate_pkg::*;
#(
  parameter int N     = NSEG,
  parameter int IDX_W = SEG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEL_W-1:0] wr_sel,
  input  seg_cache_t       wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output seg_cache_t       rd_entry,
  input  logic [IDX_W-1:0] obs_idx,
  output logic [SEL_W-1:0] obs_sel,
  output seg_cache_t       obs_entry
);
  seg_cache_t       ent_q [N];
  logic [SEL_W-1:0] sel_q [N];

  for (genvar g = 0; g < N; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q[g] <= CACHE_RESET;
        sel_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        ent_q[g] <= wr_entry;
        sel_q[g] <= wr_sel;
      end
    end
  end

  always_comb begin
    rd_entry  = CACHE_RESET;
    obs_entry = CACHE_RESET;
    obs_sel   = '0;
    if (rd_idx < IDX_W'(N)) rd_entry = ent_q[rd_idx];
    if (obs_idx < IDX_W'(N)) begin
      obs_entry = ent_q[obs_idx];
      obs_sel   = sel_q[obs_idx];
    end
  end
endmodule

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int TLIM_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_mode,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [TLIM_W-1:0] gdt_limit,
  input  logic              ld_start,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [SEL_W-1:0]  ld_sel,
  output logic              ld_busy,
  output logic              ld_done,
  output flt_e              ld_fault,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  output logic              wr_en,
  output logic [SEG_W-1:0]  wr_idx,
  output logic [SEL_W-1:0]  wr_sel,
  output seg_cache_t        wr_entry
);
  localparam int END_W = (SEL_W > TLIM_W ? SEL_W : TLIM_W) + 1;

  typedef enum logic {S_IDLE, S_FETCH} st_e;
  st_e              state;
  logic [SEG_W-1:0] seg_q;
  logic [SEL_W-1:0] sel_q;
  seg_cache_t       dec_entry, real_entry;
  flt_e             dec_fault;
  logic             seg_ok, in_tbl;
  logic [END_W-1:0] ent_end;

  seg_desc_decode u_dec (
    .desc (mem_rdata),
    .seg  (seg_q),
    .entry(dec_entry),
    .fault(dec_fault)
  );

  assign seg_ok  = ld_seg < SEG_W'(NSEG);
  assign ent_end = END_W'({ld_sel[SEL_W-1:3], 3'b111});
  assign in_tbl  = ent_end <= END_W'(gdt_limit);
  assign ld_busy = (state == S_FETCH);

  always_comb begin
    real_entry      = CACHE_RESET;
    real_entry.base = ADDR_W'({ld_sel, 4'h0});
  end

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = ld_seg;
    wr_sel   = ld_sel;
    wr_entry = real_entry;
    if (state == S_IDLE && ld_start && seg_ok && !prot_mode) begin
      wr_en = 1'b1;
    end else if (state == S_FETCH && mem_ack && dec_fault == FLT_NONE) begin
      wr_en    = 1'b1;
      wr_idx   = seg_q;
      wr_sel   = sel_q;
      wr_entry = dec_entry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      ld_done  <= 1'b0;
      ld_fault <= FLT_NONE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      seg_q    <= '0;
      sel_q    <= '0;
    end else begin
      ld_done  <= 1'b0;
      ld_fault <= FLT_NONE;
      case (state)
        S_IDLE: if (ld_start) begin
          if (!seg_ok) begin
            ld_done  <= 1'b1;
            ld_fault <= FLT_GP;
          end else if (!prot_mode) begin
            ld_done <= 1'b1;
          end else if (!in_tbl) begin
            ld_done  <= 1'b1;
            ld_fault <= FLT_GP;
          end else begin
            state    <= S_FETCH;
            mem_req  <= 1'b1;
            mem_addr <= gdt_base + ADDR_W'({ld_sel[SEL_W-1:3], 3'b000});
            seg_q    <= ld_seg;
            sel_q    <= ld_sel;
          end
        end
        S_FETCH: if (mem_ack) begin
          state    <= S_IDLE;
          mem_req  <= 1'b0;
          ld_done  <= 1'b1;
          ld_fault <= dec_fault;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [SEG_W-1:0]  seg,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] lim,
  output logic              out_valid,
  output logic [ADDR_W-1:0] linear,
  output flt_e              fault
);
  logic bad_seg, over;

  assign bad_seg = seg >= SEG_W'(NSEG);
  assign over    = offset > lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      linear    <= '0;
      fault     <= FLT_NONE;
    end else begin
      out_valid <= acc_valid;
      if (acc_valid) begin
        if (bad_seg) begin
          linear <= '0;
          fault  <= FLT_GP;
        end else if (over) begin
          linear <= '0;
          fault  <= (seg == SEG_STACK) ? FLT_SF : FLT_GP;
        end else begin
          linear <= base + offset;
          fault  <= FLT_NONE;
        end
      end
    end
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        prot_mode,
  input  logic [31:0] gdt_base,
  input  logic [15:0] gdt_limit,
  input  logic        ld_start,
  input  logic [2:0]  ld_seg,
  input  logic [15:0] ld_sel,
  output logic        ld_busy,
  output logic        ld_done,
  output logic [1:0]  ld_fault,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [63:0] mem_rdata,
  input  logic        xl_valid,
  output logic        xl_ready,
  input  logic [2:0]  xl_seg,
  input  logic [31:0] xl_offset,
  output logic        xl_out_valid,
  output logic [31:0] xl_linear,
  output logic [1:0]  xl_fault,
  input  logic [2:0]  obs_seg,
  output logic [15:0] obs_sel,
  output logic [7:0]  obs_rights,
  output logic [3:0]  obs_flags
);
  logic             wr_en;
  logic [SEG_W-1:0] wr_idx;
  logic [SEL_W-1:0] wr_sel;
  seg_cache_t       wr_entry, rd_entry, obs_entry;
  flt_e             ld_fault_e, xl_fault_e;

  assign xl_ready   = !ld_busy;
  assign ld_fault   = ld_fault_e;
  assign xl_fault   = xl_fault_e;
  assign obs_rights = obs_entry.acc;
  assign obs_flags  = obs_entry.flg;

  seg_load_ctrl #(.TLIM_W(16)) u_ctrl (
    .clk, .rst, .prot_mode, .gdt_base, .gdt_limit,
    .ld_start, .ld_seg, .ld_sel, .ld_busy, .ld_done,
    .ld_fault(ld_fault_e),
    .mem_req, .mem_addr, .mem_ack, .mem_rdata,
    .wr_en, .wr_idx, .wr_sel, .wr_entry
  );

  seg_cache_file u_cache (
    .clk, .rst, .wr_en, .wr_idx, .wr_sel, .wr_entry,
    .rd_idx(xl_seg), .rd_entry,
    .obs_idx(obs_seg), .obs_sel, .obs_entry
  );

  seg_addr_gen u_agen (
    .clk, .rst,
    .acc_valid(xl_valid && !ld_busy),
    .seg(xl_seg), .offset(xl_offset),
    .base(rd_entry.base), .lim(rd_entry.lim),
    .out_valid(xl_out_valid), .linear(xl_linear),
    .fault(xl_fault_e)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic        prot_mode,
  input logic        ld_start,
  input logic [2:0]  ld_seg,
  input logic        ld_busy,
  input logic        ld_done,
  input logic [1:0]  ld_fault,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic [2:0]  xl_seg,
  input logic        xl_out_valid,
  input logic [1:0]  xl_fault
);
  p_real_load_r1: assert property (@(posedge clk) disable iff (rst)
    ld_start && !ld_busy && !prot_mode && ld_seg < 3'd6 |=> ld_done && ld_fault == 2'd0 && !mem_req);

  p_stack_fault_seg_r3: assert property (@(posedge clk) disable iff (rst)
    xl_out_valid && xl_fault == 2'd2 |-> $past(xl_seg) == 3'd2);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_done_after_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ld_busy) |-> ld_done);

  p_fault_with_done_r6: assert property (@(posedge clk) disable iff (rst)
    ld_fault != 2'd0 |-> ld_done);

  p_no_result_busy_r11: assert property (@(posedge clk) disable iff (rst)
    ld_busy |=> !xl_out_valid);
endmodule

bind seg_xlate_unit seg_xlate_chk chk_i (
  .clk(clk), .rst(rst), .prot_mode(prot_mode), .ld_start(ld_start),
  .ld_seg(ld_seg), .ld_busy(ld_busy), .ld_done(ld_done), .ld_fault(ld_fault),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .xl_seg(xl_seg), .xl_out_valid(xl_out_valid), .xl_fault(xl_fault)
);

// File: tb/seg_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb_top;
  localparam logic [31:0] GBASE = 32'h0001_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, prot_mode = 1'b0, ld_start = 1'b0, mem_ack = 1'b0;
  logic xl_valid = 1'b0;
  logic [31:0] gdt_base = GBASE, xl_offset = '0;
  logic [15:0] gdt_limit = 16'h003F, ld_sel = '0;
  logic [2:0]  ld_seg = '0, xl_seg = '0, obs_seg = '0;
  logic [63:0] mem_rdata = '0;
  logic ld_busy, ld_done, mem_req, xl_ready, xl_out_valid;
  logic [1:0]  ld_fault, xl_fault;
  logic [31:0] mem_addr, xl_linear;
  logic [15:0] obs_sel;
  logic [7:0]  obs_rights;
  logic [3:0]  obs_flags;

  seg_xlate_unit dut_i (.*);

  int checks = 0, fails = 0, reads = 0, wcnt = 0;
  logic hold_ack = 1'b0;
  logic [31:0] last_addr = '0;
  logic [63:0] tbl [16];
  logic [31:0] m_base [6], m_lim [6];
  logic [7:0]  m_acc [6];
  logic [3:0]  m_flg [6];
  logic [15:0] m_sel [6];

  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack && !hold_ack) begin
      if (wcnt == 2) begin
        mem_ack   <= 1'b1;
        mem_rdata <= tbl[((mem_addr - GBASE) >> 3) & 32'hF];
        last_addr <= mem_addr;
        reads++;
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [31:0] b, logic [19:0] l, logic [7:0] a, logic [3:0] f);
    return {b[31:24], f, l[19:16], a, b[23:16], b[15:0], l[15:0]};
  endfunction

  task automatic set_real(int s, logic [15:0] sel);
    m_base[s] = {12'h0, sel, 4'h0}; m_lim[s] = 32'hFFFF;
    m_acc[s] = 8'h93; m_flg[s] = 4'h0; m_sel[s] = sel;
  endtask

  function automatic logic [1:0] exp_pf(int s, logic [15:0] sel);
    logic [63:0] d;
    if (s > 5) return 2'd1;
    if (int'(sel[15:3]) * 8 + 7 > int'(gdt_limit)) return 2'd1;
    d = tbl[sel[6:3]];
    if (!d[44]) return 2'd1;
    if (s == 1 && !d[43]) return 2'd1;
    if (s == 2 && d[43]) return 2'd1;
    if (!d[47]) return 2'd3;
    return 2'd0;
  endfunction

  task automatic set_prot(int s, logic [15:0] sel);
    logic [63:0] d;
    logic [31:0] raw;
    d = tbl[sel[6:3]];
    raw = {12'h0, d[51:48], d[15:0]};
    m_base[s] = {d[63:56], 24'h0} + {8'h0, d[39:32], 16'h0} + {16'h0, d[31:16]};
    m_lim[s]  = d[55] ? raw * 32'd4096 + 32'd4095 : raw;
    m_acc[s]  = d[47:40] | 8'h01;
    m_flg[s]  = d[55:52];
    m_sel[s]  = sel;
  endtask

  task automatic load(logic [2:0] s, logic [15:0] sel, output logic [1:0] f);
    @(negedge clk);
    ld_start = 1'b1; ld_seg = s; ld_sel = sel;
    @(negedge clk);
    ld_start = 1'b0;
    repeat (40) begin
      if (ld_done) break;
      @(negedge clk);
    end
    chk("R4", "done seen", ld_done, 1'b1);
    f = ld_fault;
  endtask

  task automatic xlate(logic [2:0] s, logic [31:0] off, output logic [31:0] lin, output logic [1:0] f);
    @(negedge clk);
    xl_valid = 1'b1; xl_seg = s; xl_offset = off;
    @(negedge clk);
    xl_valid = 1'b0;
    chk("R2", "out valid", xl_out_valid, 1'b1);
    lin = xl_linear; f = xl_fault;
  endtask

  task automatic check_seg(int s, string req);
    logic [31:0] lin, off;
    logic [1:0]  f;
    obs_seg = 3'(s);
    #0.1;
    chk(req, "selector", obs_sel, m_sel[s]);
    chk("R9", "rights", obs_rights, m_acc[s]);
    chk("R9", "flags", obs_flags, m_flg[s]);
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: off = 32'h0;
        1: off = m_lim[s] >> 1;
        2: off = m_lim[s];
        default: off = m_lim[s] + 32'd1;
      endcase
      if (k == 3 && m_lim[s] == 32'hFFFF_FFFF) continue;
      xlate(3'(s), off, lin, f);
      if (off <= m_lim[s]) begin
        chk("R2", "linear", lin, m_base[s] + off);
        chk("R2", "fault", f, 2'd0);
      end else begin
        chk("R3", "limit fault", f, (s == 2) ? 2'd2 : 2'd1);
        chk("R3", "faulted linear", lin, 32'h0);
      end
    end
  endtask

  initial begin
    logic [1:0] f;
    logic [31:0] lin;
    logic [15:0] rsel [4];
    int r0;
    rsel[0] = 16'h0000; rsel[1] = 16'h1234; rsel[2] = 16'hFFFF; rsel[3] = 16'h8001;
    for (int i = 0; i < 16; i++) tbl[i] = '0;
    tbl[1] = mk(32'h0012_0000, 20'h0FFFF, 8'h9A, 4'h4);
    tbl[2] = mk(32'hAB34_5678, 20'h00003, 8'h92, 4'hC);
    tbl[3] = mk(32'h0000_5000, 20'h000FF, 8'h12, 4'h0);
    tbl[4] = mk(32'h0000_7000, 20'h00067, 8'h89, 4'h0);
    tbl[5] = mk(32'h0000_9000, 20'h00FFF, 8'h1A, 4'h4);
    tbl[6] = mk(32'h0000_0000, 20'hFFFFF, 8'h93, 4'hC);
    tbl[7] = mk(32'hFFFF_FF00, 20'h00010, 8'h92, 4'h1);
    tbl[8] = tbl[1];
    tbl[9] = tbl[2];
    for (int s = 0; s < 6; s++) set_real(s, 16'h0);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", "busy", ld_busy, 1'b0);
    chk("R12", "done", ld_done, 1'b0);
    chk("R12", "mem_req", mem_req, 1'b0);
    chk("R12", "out valid", xl_out_valid, 1'b0);
    chk("R12", "ready", xl_ready, 1'b1);
    for (int s = 0; s < 6; s++) check_seg(s, "R12");

    // R1: real-mode loads over all segments and several selectors
    for (int s = 0; s < 7; s++) begin
      for (int j = 0; j < 4; j++) begin
        r0 = reads;
        load(3'(s), rsel[j], f);
        chk("R1", "real fault", f, (s > 5) ? 2'd1 : 2'd0);
        chk("R1", "no read", reads, r0);
        if (s < 6) begin
          set_real(s, rsel[j]);
          check_seg(s, "R1");
        end
      end
    end
    xlate(3'd6, 32'h0, lin, f);
    chk("R3", "invalid segment", f, 2'd1);
    xlate(3'd7, 32'h10, lin, f);
    chk("R3", "invalid segment", f, 2'd1);

    // R4-R9: protected-mode sweep over segments and table entries
    prot_mode = 1'b1;
    for (int s = 0; s < 7; s++) begin
      for (int i = 0; i < 10; i++) begin
        logic [15:0] sel;
        logic [1:0]  ef;
        logic        fits;
        sel  = 16'(i * 8 + (s & 3));
        ef   = exp_pf(s, sel);
        fits = (s < 6) && (i * 8 + 7 <= int'(gdt_limit));
        r0 = reads;
        load(3'(s), sel, f);
        chk(ef == 2'd3 ? "R8" : (fits ? "R7" : "R6"), "load fault", f, ef);
        chk("R4", "read count", reads, r0 + (fits ? 1 : 0));
        if (fits) chk("R4", "read address", last_addr, GBASE + 32'(i * 8));
        if (ef == 2'd0) set_prot(s, sel);
        if (s < 6) check_seg(s, ef == 2'd0 ? "R5" : "R7");
      end
    end

    // R10: mode switches keep caches
    prot_mode = 1'b0;
    for (int s = 0; s < 6; s++) check_seg(s, "R10");
    load(3'd3, 16'h2000, f);
    chk("R10", "real reload", f, 2'd0);
    set_real(3, 16'h2000);
    for (int s = 0; s < 6; s++) check_seg(s, "R10");
    prot_mode = 1'b1;
    for (int s = 0; s < 6; s++) check_seg(s, "R10");

    // R11: stall while a fetch is outstanding
    hold_ack = 1'b1;
    r0 = reads;
    @(negedge clk);
    ld_start = 1'b1; ld_seg = 3'd4; ld_sel = 16'h0010;
    @(negedge clk);
    ld_start = 1'b0;
    chk("R11", "busy", ld_busy, 1'b1);
    chk("R11", "ready low", xl_ready, 1'b0);
    xl_valid = 1'b1; xl_seg = 3'd0; xl_offset = 32'h0;
    @(negedge clk);
    xl_valid = 1'b0;
    chk("R11", "no result", xl_out_valid, 1'b0);
    ld_start = 1'b1; ld_seg = 3'd0; ld_sel = 16'h0030;
    @(negedge clk);
    ld_start = 1'b0;
    chk("R11", "no result", xl_out_valid, 1'b0);
    hold_ack = 1'b0;
    repeat (40) begin
      if (ld_done) break;
      @(negedge clk);
    end
    chk("R11", "fetch fault", ld_fault, 2'd0);
    repeat (3) @(negedge clk);
    chk("R11", "single read", reads, r0 + 1);
    set_prot(4, 16'h0010);
    check_seg(4, "R11");
    check_seg(0, "R11");

    summary();
    $finish;
  end
endmodule